// File: doc/BRIEF.md
# Two-Miss Hysteresis Branch Direction Predictor

This block predicts the direction of one conditional branch. It is a four-state Moore machine whose two state bits also act as its outputs. The upper bit is the current guess, where 1 means taken. The lower bit remembers the most recent resolved outcome. The surrounding pipeline reads `pred_taken` at any time. Whenever a branch resolves, it presents the real direction on `outcome_taken` together with `outcome_valid` for one clock.

The machine has hysteresis. A single outcome that disagrees with the guess only marks the state as weak. The guess flips only when a second disagreeing outcome follows directly after the first. This is not a saturating counter. In a weak state, one agreeing outcome returns the machine straight to the matching strong state.

The next state is built from four small candidate functions, one for each possible current state. A multiplexer indexed by the current state picks one of them. The result loads a two-bit register on the rising clock edge.

Top module: `bp_hyst_predictor`

## Requirements
- R1: A synchronous active-high `rst` sampled on a rising edge sets the state to 0, which is strong not-taken (`state_q` = 2'b00, `pred_taken` = 0). Reset takes priority over `outcome_valid`.
- R2: On a rising edge where `outcome_valid` is 0, `state_q` and `pred_taken` keep their values, whatever `outcome_taken` carries.
- R3: `pred_taken` always equals `state_q[1]`. State encoding: 0 = strong not-taken, 1 = weak not-taken, 2 = weak taken, 3 = strong taken.
- R4: After an accepted update, `state_q[0]` equals the outcome that was accepted (taken = 1, not taken = 0).
- R5: From a strong state (0 or 3), a single disagreeing outcome keeps the prediction and moves the machine to the weak state of the same prediction: 3 goes to 2, and 0 goes to 1.
- R6: From a weak state (1 or 2), a disagreeing outcome flips the prediction and lands in the opposite strong state: 2 goes to 0, and 1 goes to 3. Two disagreeing outcomes in a row from a strong state therefore flip the prediction.
- R7: From a weak state, an agreeing outcome returns the machine directly to the strong state of the same prediction: 2 goes to 3, and 1 goes to 0.
- R8: In a strong state, an agreeing outcome leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| outcome_valid | input | 1 | Qualifies `outcome_taken` for an update on this edge |
| outcome_taken | input | 1 | Resolved direction: 1 taken, 0 not taken |
| pred_taken | output | 1 | Current direction prediction |
| state_q | output | 2 | Current state {prediction, last outcome} |

## Verification
The hardest case to reach is a disagreeing outcome that arrives while the machine is already weak. That is the only place the prediction can change. It needs a specific two-outcome history, and no idle cycle between the two outcomes may disturb it.

Directed sequences build that history explicitly in both directions:
- taken, not-taken, taken from strong not-taken, which must not flip the prediction;
- two not-taken outcomes from strong taken, which must flip it.

A long random run then mixes in idle cycles so that every state is reached with both outcome values. Each cycle is compared against a behavioural model.

// File: rtl/bp_hyst_pkg.sv
package bp_hyst_pkg;
  localparam int unsigned STATE_W    = 2;
  localparam int unsigned NUM_STATES = 1 << STATE_W;

  typedef enum logic [STATE_W-1:0] {
    ST_STRONG_NT = 2'd0,
    ST_WEAK_NT   = 2'd1,
    ST_WEAK_T    = 2'd2,
    ST_STRONG_T  = 2'd3
  } hyst_state_e;
endpackage

// File: rtl/bp_hyst_cand.sv
// Next-state candidate for one fixed current state.
module bp_hyst_cand
  import bp_hyst_pkg::*;
#(
  parameter int unsigned STATE_ID = 0
) (
  input  logic               outcome_i,
  output logic [STATE_W-1:0] next_o
);
  localparam logic [STATE_W-1:0] ID = STATE_W'(STATE_ID);
  localparam logic PRED = ID[STATE_W-1];
  localparam logic LAST = ID[0];

  // The prediction moves only when the stored outcome and the new one both disagree with it.
  always_comb begin
    if ((LAST != PRED) && (outcome_i != PRED)) begin
      next_o = {outcome_i, outcome_i};
    end else begin
      next_o = {PRED, outcome_i};
    end
  end
endmodule

// File: rtl/bp_hyst_sel.sv
// Picks the candidate that belongs to the current state.
module bp_hyst_sel
  import bp_hyst_pkg::*;
(
  input  logic [NUM_STATES-1:0][STATE_W-1:0] cand_i,
  input  logic [STATE_W-1:0]                 sel_i,
  output logic [STATE_W-1:0]                 y_o
);
  always_comb y_o = cand_i[sel_i];
endmodule

// File: rtl/bp_hyst_reg.sv
module bp_hyst_reg
  import bp_hyst_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [STATE_W-1:0] d_i,
  output logic [STATE_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= ST_STRONG_NT;
    end else if (load_i) begin
      q_o <= d_i;
    end
  end

  // R1
  p_reset_state_r1: assert property (@(posedge clk) rst |=> (q_o == '0));

  // R2
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/bp_hyst_predictor.sv
module bp_hyst_predictor
  import bp_hyst_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               outcome_valid,
  input  logic               outcome_taken,
  output logic               pred_taken,
  output logic [STATE_W-1:0] state_q
);
  logic [NUM_STATES-1:0][STATE_W-1:0] cand;
  logic [STATE_W-1:0]                 next_state;

  // One candidate generator for each state.
  for (genvar g = 0; g < NUM_STATES; g++) begin : g_cand
    bp_hyst_cand #(.STATE_ID(g)) u_cand (
      .outcome_i (outcome_taken),
      .next_o    (cand[g])
    );
  end

  bp_hyst_sel u_sel (
    .cand_i (cand),
    .sel_i  (state_q),
    .y_o    (next_state)
  );

  bp_hyst_reg u_reg (
    .clk    (clk),
    .rst    (rst),
    .load_i (outcome_valid),
    .d_i    (next_state),
    .q_o    (state_q)
  );

  assign pred_taken = state_q[STATE_W-1];

  // R4
  p_last_tracks_r4: assert property (@(posedge clk) disable iff (rst)
    outcome_valid |=> (state_q[0] == $past(outcome_taken)));

  // R5
  p_strong_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (outcome_valid && (state_q[1] == state_q[0])) |=> (pred_taken == $past(pred_taken)));

  // R6
  p_second_miss_flips_r6: assert property (@(posedge clk) disable iff (rst)
    (outcome_valid && (state_q[1] != state_q[0]) && (outcome_taken != state_q[1]))
      |=> (pred_taken != $past(pred_taken)) && (state_q[1] == state_q[0]));

  // R7
  p_weak_recovers_r7: assert property (@(posedge clk) disable iff (rst)
    (outcome_valid && (state_q[1] != state_q[0]) && (outcome_taken == state_q[1]))
      |=> (pred_taken == $past(pred_taken)) && (state_q[1] == state_q[0]));
endmodule

// File: tb/bp_hyst_predictor_tb.sv
`timescale 1ns/1ps
module bp_hyst_predictor_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       outcome_valid = 1'b0;
  logic       outcome_taken = 1'b0;
  logic       pred_taken;
  logic [1:0] state_q;

  int checks = 0;
  int fails  = 0;
  int m_pred = 0;
  int m_last = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bp_hyst_predictor u_dut (
    .clk           (clk),
    .rst           (rst),
    .outcome_valid (outcome_valid),
    .outcome_taken (outcome_taken),
    .pred_taken    (pred_taken),
    .state_q       (state_q)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic string classify(input bit v, input int o);
    if (!v) return "R2";
    if (m_pred == m_last) return (o == m_pred) ? "R8" : "R5";
    return (o == m_pred) ? "R7" : "R6";
  endfunction

  // One clock: drive at negedge, update model, sample 1 ns after the edge.
  task automatic step(input bit v, input int o);
    string tag;
    @(negedge clk);
    outcome_valid = v;
    outcome_taken = o[0];
    tag = classify(v, o);
    @(posedge clk);
    if (v) begin
      if ((m_last != m_pred) && (o != m_pred)) m_pred = o;
      m_last = o;
    end
    #1;
    check({tag, " state"}, int'(state_q), m_pred * 2 + m_last);
    check("R3 pred", int'(pred_taken), m_pred);
    if (v) check("R4 last", int'(state_q[0]), o);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    outcome_valid = 1'b1;
    outcome_taken = 1'b1;
    @(posedge clk);
    #1;
    m_pred = 0;
    m_last = 0;
    check("R1 reset state", int'(state_q), 0);
    check("R1 reset pred", int'(pred_taken), 0);
    @(negedge clk);
    rst = 1'b0;
    outcome_valid = 1'b0;
  endtask

  initial begin
    #200_000_000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R5 then R6 with R7: taken, not-taken, taken from strong not-taken, no flip.
    step(1, 1); check("R5 0->1", int'(state_q), 1);
    step(1, 0); check("R7 1->0", int'(state_q), 0);
    step(1, 1); check("R5 no flip", int'(pred_taken), 0);
    // R6: second taken in a row flips to strong taken.
    step(1, 1); check("R6 1->3", int'(state_q), 3);
    // R8: agreement in strong taken stays.
    step(1, 1); check("R8 3 stays", int'(state_q), 3);
    // R2: idle cycles ignore the outcome pin.
    step(0, 0); check("R2 idle hold", int'(state_q), 3);
    step(0, 1); check("R2 idle hold", int'(state_q), 3);
    // Two not-taken from strong taken flip the prediction.
    step(1, 0); check("R5 3->2", int'(state_q), 2);
    step(0, 0); check("R2 weak hold", int'(state_q), 2);
    step(1, 0); check("R6 2->0", int'(state_q), 0);
    // R7: weak taken recovers to strong taken.
    step(1, 1); step(1, 1); step(1, 0); step(1, 1);
    check("R7 2->3", int'(state_q), 3);
    // R1: reset from strong taken, with valid high.
    do_reset();
    for (int i = 0; i < 2000; i++) begin
      step(($urandom % 4) != 0, int'($urandom % 2));
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule